// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status Flags

This block takes in asynchronous serial frames on a single line and delivers each received byte in a holding register. A frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit, and a high stop bit. The line rests high between frames. A single-cycle enable pulse at sixteen times the bit rate paces the receiver. Each bit is sampled once, near its middle.

Four sticky flags describe the state of the holding register. One flag reports that the register holds unread data. The other three report an overrun, a bad stop bit and a parity mismatch. One shared enable bit gates two level interrupt requests: a data request and an error request. Software clears each flag on its own with a write-zero strobe. When a frame ends in any error, the receiver does not start another frame until software has cleared all four flags.

Top module: `uart_rx_core`

## Requirements
- R1: The line idles high. A frame is a 0 start bit, data bits D0 to D7 in that order, a parity bit only when `par_en_i` is 1, and a stop bit. A frame with no error copies the byte to `rx_data_o` and sets `full_o`.
- R2: A falling edge on the synchronised line starts a frame only if the line is still 0 at the 8th oversampling pulse after the edge. If the line is high at that point, the receiver returns to idle and loads nothing.
- R3: `irq_rx_o` is 1 exactly when `irq_en_i` is 1 and `full_o` is 1.
- R4: `irq_err_o` is 1 exactly when `irq_en_i` is 1 and at least one of `ovr_o`, `frm_o` or `par_o` is 1.
- R5: When a frame completes while `full_o` is 1, `ovr_o` is set. `rx_data_o` keeps its old value and `full_o` stays 1.
- R6: When the sampled stop bit is 0, `frm_o` is set and the byte is still copied to `rx_data_o`. `full_o` keeps its previous value of 0.
- R7: With parity enabled, the expected parity bit is the XOR of the eight data bits when `par_odd_i` is 0, and the inverse of that XOR when `par_odd_i` is 1. On a mismatch, `par_o` is set and the byte is still copied. `full_o` keeps its previous value of 0.
- R8: After a frame ends in an error, no new frame is received until `full_o`, `ovr_o`, `frm_o` and `par_o` are all 0. Frames sent during that time leave every output unchanged.
- R9: Each flag has its own clear strobe (`wr0_full_i`, `wr0_ovr_i`, `wr0_frm_i`, `wr0_par_i`). A strobe clears only its own flag, on the next clock edge.
- R10: After reset, `rx_data_o` is 0 and every flag and interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line (asynchronous) |
| os_tick_i | input | 1 | Single-cycle pulse at 16x the bit rate |
| par_en_i | input | 1 | A parity bit follows the data bits |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| irq_en_i | input | 1 | Shared enable for both interrupt requests |
| wr0_full_i | input | 1 | Clear strobe for the data-full flag |
| wr0_ovr_i | input | 1 | Clear strobe for the overrun flag |
| wr0_frm_i | input | 1 | Clear strobe for the framing flag |
| wr0_par_i | input | 1 | Clear strobe for the parity flag |
| rx_data_o | output | 8 | Receive holding register |
| full_o | output | 1 | Holding register has unread data |
| ovr_o | output | 1 | Sticky overrun flag |
| frm_o | output | 1 | Sticky framing-error flag |
| par_o | output | 1 | Sticky parity-error flag |
| irq_rx_o | output | 1 | Receive-data interrupt request |
| irq_err_o | output | 1 | Receive-error interrupt request |

## Verification
The properties assume that `os_tick_i` is a single-cycle pulse with idle cycles between pulses. They also assume that the line changes only at bit boundaries 16 pulses apart and holds each level for a full bit. The bench produces the tick from a fixed divide-by-four counter and holds every bit for exactly sixteen pulses. Clear strobes and configuration changes happen only while the line is idle between frames, so no clear strobe lands on the same cycle as a frame completing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned BYTE_W = 8;

  // bit positions inside the error-flag vector
  localparam int unsigned ERR_OVR = 0;
  localparam int unsigned ERR_FRM = 1;
  localparam int unsigned ERR_PAR = 2;
  localparam int unsigned ERR_N   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              stop_ok;
    logic              par_ok;
  } rx_frame_t;

  // parity bit the sender must append for the chosen sense
  function automatic logic parity_expect(input logic [BYTE_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o,
  output logic fall_o
);

  logic [STAGES-1:0] pipe_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      last_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], line_i};
      last_q <= pipe_q[STAGES-1];
    end
  end

  assign line_o = pipe_q[STAGES-1];
  assign fall_o = last_q & ~pipe_q[STAGES-1];

endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      line_i,
  input  logic      fall_i,
  input  logic      halt_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  output logic      done_o,
  output rx_frame_t frame_o,
  output logic      idle_o
);

  localparam int unsigned CNT_W  = $clog2(OSR);
  localparam int unsigned IDX_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] shr_q;
  logic              par_bit_q;
  logic              stop_bit_q;
  logic              done_q;
  logic              at_mid;

  assign at_mid = tick_i && (cnt_q == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      shr_q      <= '0;
      par_bit_q  <= 1'b0;
      stop_bit_q <= 1'b1;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (fall_i && !halt_i) state_q <= ST_START;
        end
        ST_START: begin
          if (tick_i) begin
            if (cnt_q == MID_CNT) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              state_q <= line_i ? ST_IDLE : ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (at_mid) begin
            cnt_q <= '0;
            shr_q <= {line_i, shr_q[BYTE_W-1:1]};
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) state_q <= par_en_i ? ST_PAR : ST_STOP;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_mid) begin
            cnt_q     <= '0;
            par_bit_q <= line_i;
            state_q   <= ST_STOP;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_mid) begin
            cnt_q      <= '0;
            stop_bit_q <= line_i;
            done_q     <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o          = done_q;
  assign idle_o          = (state_q == ST_IDLE);
  assign frame_o.data    = shr_q;
  assign frame_o.stop_ok = stop_bit_q;
  assign frame_o.par_ok  = !par_en_i || (par_bit_q == parity_expect(shr_q, par_odd_i));

endmodule

// File: rtl/rx_flag_bank.sv
module rx_flag_bank
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  rx_frame_t         frame_i,
  input  logic              wr0_full_i,
  input  logic [ERR_N-1:0]  wr0_err_i,
  input  logic              irq_en_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              full_o,
  output logic [ERR_N-1:0]  err_o,
  output logic              halt_o,
  output logic              irq_rx_o,
  output logic              irq_err_o
);

  logic              full_q;
  logic [ERR_N-1:0]  err_q;
  logic [ERR_N-1:0]  err_ev;
  logic [BYTE_W-1:0] data_q;
  logic              halt_q;
  logic              load_ev;
  logic              good_ev;

  assign load_ev          = done_i && !full_q;
  assign err_ev[ERR_OVR]  = done_i && full_q;
  assign err_ev[ERR_FRM]  = load_ev && !frame_i.stop_ok;
  assign err_ev[ERR_PAR]  = load_ev && !frame_i.par_ok;
  assign good_ev          = load_ev && frame_i.stop_ok && frame_i.par_ok;

  for (genvar g = 0; g < ERR_N; g++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            err_q[g] <= 1'b0;
      else if (err_ev[g])    err_q[g] <= 1'b1;
      else if (wr0_err_i[g]) err_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      halt_q <= 1'b0;
    end else begin
      if (good_ev)         full_q <= 1'b1;
      else if (wr0_full_i) full_q <= 1'b0;
      if (load_ev) data_q <= frame_i.data;
      if (|err_ev)                  halt_q <= 1'b1;
      else if (!full_q && !(|err_q)) halt_q <= 1'b0;
    end
  end

  assign data_o    = data_q;
  assign full_o    = full_q;
  assign err_o     = err_q;
  assign halt_o    = halt_q;
  assign irq_rx_o  = irq_en_i & full_q;
  assign irq_err_o = irq_en_i & (|err_q);

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              os_tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              irq_en_i,
  input  logic              wr0_full_i,
  input  logic              wr0_ovr_i,
  input  logic              wr0_frm_i,
  input  logic              wr0_par_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              frm_o,
  output logic              par_o,
  output logic              irq_rx_o,
  output logic              irq_err_o
);

  logic             line_s;
  logic             line_fall;
  logic             frame_done;
  rx_frame_t        frame;
  logic             eng_idle;
  logic             rx_halt;
  logic [ERR_N-1:0] err_flags;
  logic [ERR_N-1:0] err_clr;

  assign err_clr[ERR_OVR] = wr0_ovr_i;
  assign err_clr[ERR_FRM] = wr0_frm_i;
  assign err_clr[ERR_PAR] = wr0_par_i;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (rxd_i),
    .line_o (line_s),
    .fall_o (line_fall)
  );

  rx_frame_engine #(.OSR(OSR)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (os_tick_i),
    .line_i    (line_s),
    .fall_i    (line_fall),
    .halt_i    (rx_halt),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .done_o    (frame_done),
    .frame_o   (frame),
    .idle_o    (eng_idle)
  );

  rx_flag_bank u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (frame_done),
    .frame_i    (frame),
    .wr0_full_i (wr0_full_i),
    .wr0_err_i  (err_clr),
    .irq_en_i   (irq_en_i),
    .data_o     (rx_data_o),
    .full_o     (full_o),
    .err_o      (err_flags),
    .halt_o     (rx_halt),
    .irq_rx_o   (irq_rx_o),
    .irq_err_o  (irq_err_o)
  );

  assign ovr_o = err_flags[ERR_OVR];
  assign frm_o = err_flags[ERR_FRM];
  assign par_o = err_flags[ERR_PAR];

endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk
  import uart_rx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              irq_en_i,
  input logic              wr0_full_i,
  input logic              wr0_ovr_i,
  input logic              frame_done,
  input rx_frame_t         frame,
  input logic              eng_idle,
  input logic              rx_halt,
  input logic [BYTE_W-1:0] rx_data_o,
  input logic              full_o,
  input logic              ovr_o,
  input logic              frm_o,
  input logic              par_o,
  input logic              irq_rx_o,
  input logic              irq_err_o
);

  p_good_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !full_o && frame.stop_ok && frame.par_ok
    |=> full_o && rx_data_o == $past(frame.data));

  p_irq_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_o) && irq_en_i |-> irq_rx_o);

  p_irq_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err_o |-> irq_en_i && (ovr_o || frm_o || par_o));

  p_overrun_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && full_o && !wr0_full_i |=> ovr_o && full_o && $stable(rx_data_o));

  p_err_copies_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !full_o && !(frame.stop_ok && frame.par_ok)
    |=> !full_o && rx_data_o == $past(frame.data));

  p_halt_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_halt && eng_idle |=> eng_idle);

  p_clear_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr0_ovr_i && !(frame_done && full_o) |=> !ovr_o);

endmodule

bind uart_rx_core uart_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_en_i   (irq_en_i),
  .wr0_full_i (wr0_full_i),
  .wr0_ovr_i  (wr0_ovr_i),
  .frame_done (frame_done),
  .frame      (frame),
  .eng_idle   (eng_idle),
  .rx_halt    (rx_halt),
  .rx_data_o  (rx_data_o),
  .full_o     (full_o),
  .ovr_o      (ovr_o),
  .frm_o      (frm_o),
  .par_o      (par_o),
  .irq_rx_o   (irq_rx_o),
  .irq_err_o  (irq_err_o)
);

// File: tb/sim_uart_rx_core.sv
`timescale 1ns/1ps
module sim_uart_rx_core;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic tick = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0, irq_en = 1'b0;
  logic wr0_full = 1'b0, wr0_ovr = 1'b0, wr0_frm = 1'b0, wr0_par = 1'b0;
  logic [7:0] rx_data;
  logic full, ovr, frm, par, irq_rx, irq_err;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [7:0] data;
    logic full, ovr, frm, par;
    string req;
  } exp_t;

  exp_t exp_q[$];
  event frame_ev;
  logic monitor_idle = 1'b1;

  // bench-side model of the flags
  logic [7:0] m_data = 8'h00;
  logic m_full = 1'b0, m_ovr = 1'b0, m_frm = 1'b0, m_par = 1'b0, m_halt = 1'b0;

  always #10 clk = ~clk;

  int tick_cnt = 0;
  always @(posedge clk) begin
    tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    tick     <= (tick_cnt == TICK_DIV - 1);
  end

  uart_rx_core u0 (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .os_tick_i(tick),
    .par_en_i(par_en), .par_odd_i(par_odd), .irq_en_i(irq_en),
    .wr0_full_i(wr0_full), .wr0_ovr_i(wr0_ovr), .wr0_frm_i(wr0_frm), .wr0_par_i(wr0_par),
    .rx_data_o(rx_data), .full_o(full), .ovr_o(ovr), .frm_o(frm), .par_o(par),
    .irq_rx_o(irq_rx), .irq_err_o(irq_err)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic check_all(input string req, input exp_t e);
    check(req, "rx_data", rx_data, e.data);
    check(req, "full", {7'd0, full}, {7'd0, e.full});
    check(req, "ovr", {7'd0, ovr}, {7'd0, e.ovr});
    check(req, "frm", {7'd0, frm}, {7'd0, e.frm});
    check(req, "par", {7'd0, par}, {7'd0, e.par});
    check("R3", "irq_rx", {7'd0, irq_rx}, {7'd0, irq_en & e.full});
    check("R4", "irq_err", {7'd0, irq_err}, {7'd0, irq_en & (e.ovr | e.frm | e.par)});
  endtask

  function automatic exp_t snap(input string req);
    exp_t e;
    e.data = m_data; e.full = m_full; e.ovr = m_ovr; e.frm = m_frm; e.par = m_par;
    e.req = req;
    return e;
  endfunction

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  // driver: model update, push expectation, then send the frame
  task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic stop, input string req);
    logic pb;
    pb = (^d) ^ par_odd ^ bad_par;
    if (!m_halt) begin
      if (m_full) begin
        m_ovr = 1'b1; m_halt = 1'b1;
      end else begin
        m_data = d;
        if (!stop) m_frm = 1'b1;
        if (par_en && bad_par) m_par = 1'b1;
        if (stop && !(par_en && bad_par)) m_full = 1'b1;
        else m_halt = 1'b1;
      end
    end
    exp_q.push_back(snap(req));
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (par_en) drive_bit(pb);
    drive_bit(stop);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    ->frame_ev;
    repeat (BIT_CLK) @(negedge clk);
    wait (monitor_idle);
  endtask

  task automatic clear(input logic cf, input logic co, input logic cfr, input logic cp);
    @(negedge clk);
    wr0_full = cf; wr0_ovr = co; wr0_frm = cfr; wr0_par = cp;
    @(negedge clk);
    wr0_full = 1'b0; wr0_ovr = 1'b0; wr0_frm = 1'b0; wr0_par = 1'b0;
    if (cf) m_full = 1'b0;
    if (co) m_ovr = 1'b0;
    if (cfr) m_frm = 1'b0;
    if (cp) m_par = 1'b0;
    if (!(m_full | m_ovr | m_frm | m_par)) m_halt = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: pop and compare after each frame
  initial begin
    forever begin
      @(frame_ev);
      monitor_idle = 1'b0;
      @(negedge clk);
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL scoreboard empty actual=0 expected=1");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check_all(e.req, e);
      end
      monitor_idle = 1'b1;
    end
  end

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check_all("R10", snap("R10"));   // reset state
    rst_n = 1'b1;
    irq_en = 1'b1;
    repeat (8) @(negedge clk);

    send_frame(8'hA5, 1'b0, 1'b1, "R1");   // clean frame, no parity
    send_frame(8'h3C, 1'b0, 1'b1, "R5");   // overrun: data stays A5
    send_frame(8'h11, 1'b0, 1'b1, "R8");   // halted: nothing changes
    clear(1'b0, 1'b1, 1'b0, 1'b0);         // R9: ovr only, full remains
    check_all("R9", snap("R9"));
    send_frame(8'h22, 1'b0, 1'b1, "R8");   // full still set: still halted
    clear(1'b1, 1'b0, 1'b0, 1'b0);
    check_all("R9", snap("R9"));

    par_en = 1'b1; par_odd = 1'b0;
    send_frame(8'h5A, 1'b0, 1'b1, "R7");   // even parity, correct
    clear(1'b1, 1'b0, 1'b0, 1'b0);
    par_odd = 1'b1;
    send_frame(8'h0F, 1'b1, 1'b1, "R7");   // odd parity, wrong bit
    clear(1'b0, 1'b0, 1'b0, 1'b1);
    send_frame(8'hE6, 1'b0, 1'b1, "R7");   // odd parity, correct
    clear(1'b1, 1'b0, 1'b0, 1'b0);

    par_en = 1'b0;
    send_frame(8'h81, 1'b0, 1'b0, "R6");   // stop bit low
    clear(1'b0, 1'b0, 1'b1, 1'b0);

    // R2: short low pulse, then line high past the start-bit middle
    rxd = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    check_all("R2", snap("R2"));
    send_frame(8'hC3, 1'b0, 1'b1, "R2");
    clear(1'b1, 1'b0, 1'b0, 1'b0);

    irq_en = 1'b0;
    send_frame(8'h77, 1'b0, 1'b1, "R3");   // full set, irq masked
    clear(1'b1, 1'b0, 1'b0, 1'b0);
    check_all("R9", snap("R9"));

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule